// File: doc/BRIEF.md
# ADC Sample Capture to Memory Writer

This block records a run of converter samples into external memory. The converter presents an 8-bit word and a strobe that is high for one clock whenever the word is new. Each accepted sample goes into a small on-chip FIFO. A write engine empties the FIFO onto a pipelined Wishbone master port. It issues one write per sample at consecutive word addresses, starting from a configured base.

Memory writes can be held off for tens of clocks, by a slow first access or by a refresh, while the converter keeps producing samples at a fixed pace. The FIFO absorbs that gap. The engine waits until a small batch of samples has built up, then opens a bus cycle and streams requests back to back. It keeps the cycle open until every write has been acknowledged.

A start pulse loads the base address and the sample count. When the last write is acknowledged, a done flag rises. A sticky flag reports any sample lost because the FIFO was full.

Top module: `adc_burst_writer`

## Requirements
- R1: While a capture is running, each strobe that finds the FIFO not full stores one sample. Capture ends once `cfg_len` samples are stored. Strobes after that point produce no memory write.
- R2: The k-th stored sample (k counted from 0) is written with data equal to that sample at word address `cfg_base + k`. Each request has `wb_we` high and `wb_cyc` high.
- R3: While capture is running and the FIFO holds fewer than BURST_THR (default 4) samples, the bus stays idle (`wb_cyc` low). Reaching BURST_THR samples opens a bus cycle.
- R4: Once capture has ended, any samples left in the FIFO are written even when they number fewer than BURST_THR.
- R5: A request is taken only on a clock where `wb_stb` is high and `wb_stall` is low. While stalled, `wb_stb`, `wb_adr` and `wb_dat_o` hold their values.
- R6: At most MAX_OUT (default 4) requests are outstanding without acknowledgement. At that limit `wb_stb` is low.
- R7: `wb_cyc` stays high until every issued request has been acknowledged. It falls once nothing is outstanding and the FIFO is empty.
- R8: A strobe arriving while capture is running and the FIFO is full discards that sample and sets `overflow`. The flag stays set until the next accepted start.
- R9: `done` rises on the clock after the acknowledgement of the `cfg_len`-th write and stays high until the next accepted start. With `cfg_len` = 0, `done` is high on the clock after start and no bus cycle occurs.
- R10: A start pulse is ignored while the block is busy, that is while capture is running, `wb_cyc` is high or the FIFO is not empty.
- R11: After reset `wb_cyc`, `wb_stb`, `done` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a capture run; loads base and length |
| cfg_base | input | ADDR_W | First word address of the run |
| cfg_len | input | LEN_W | Number of samples to record |
| adc_data | input | DATA_W | Converter sample |
| adc_strobe | input | 1 | One-clock valid for `adc_data` |
| wb_cyc | output | 1 | Bus cycle open |
| wb_stb | output | 1 | Request strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | ADDR_W | Word address |
| wb_dat_o | output | DATA_W | Write data |
| wb_stall | input | 1 | Target cannot take a request this clock |
| wb_ack | input | 1 | One request completed |
| done | output | 1 | All samples of the run written |
| overflow | output | 1 | Sticky: a sample was lost to a full FIFO |

## Verification
The bench targets several corner cases.

- **Stalled requests.** A design that advanced its address or data while stalled would leave holes or duplicates in the memory image.
- **Short runs and tails.** A run shorter than the batch threshold, or a tail left over after the last full batch, would hang without `done` if the flush rule were missing.
- **Held acknowledgements.** When acknowledgements are withheld, a design with no cap on outstanding requests would issue too many. One that dropped `wb_cyc` early would let completions go uncounted.
- **Lost samples, stray starts and zero length.** The bench forces samples into a full FIFO, sends a start in the middle of a run, and starts a run of zero length. Errors here show up as a missing overflow flag, writes redirected to the new base, or a run that never reports done.

// File: rtl/adcw_pkg.sv
package adcw_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_OPEN = 1'b1
    } bus_state_e;

    // one bus event per clock: request taken, completion seen
    typedef struct packed {
        logic taken;
        logic acked;
    } bus_evt_t;

    // a batch may start on a full batch, or on any leftover once capture is over
    function automatic logic batch_ready(input logic at_thr,
                                         input logic capture_over,
                                         input logic fifo_empty);
        return at_thr | (capture_over & ~fifo_empty);
    endfunction

endpackage

// File: rtl/adcw_fifo.sv
module adcw_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic [LVL_W-1:0]  level
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [AW:0]       wr_ptr;
    logic [AW:0]       rd_ptr;

    assign level = wr_ptr - rd_ptr;
    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign dout  = store[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            store[wr_ptr[AW-1:0]] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop && !empty) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adcw_capture.sv
module adcw_capture #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_ok,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             strobe,
    input  logic             fifo_full,
    output logic             push,
    output logic             capturing,
    output logic             overflow
);
    logic [LEN_W-1:0] stored;
    logic [LEN_W-1:0] run_len;

    assign push = capturing && strobe && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored    <= '0;
            run_len   <= '0;
            capturing <= 1'b0;
            overflow  <= 1'b0;
        end else if (start_ok) begin
            stored    <= '0;
            run_len   <= cfg_len;
            capturing <= (cfg_len != '0);
            overflow  <= 1'b0;
        end else begin
            if (push) begin
                stored <= stored + 1'b1;
                if (stored + 1'b1 == run_len) begin
                    capturing <= 1'b0;
                end
            end
            if (capturing && strobe && fifo_full) begin
                overflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adcw_wb_engine.sv
module adcw_wb_engine
    import adcw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int LEN_W     = 12,
    parameter int LVL_W     = 5,
    parameter int BURST_THR = 4,
    parameter int MAX_OUT   = 4,
    localparam int OUT_W    = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              capturing,
    input  logic              fifo_empty,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [DATA_W-1:0] fifo_dout,
    output logic              pop,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic              wb_stall,
    input  logic              wb_ack,
    output logic              done
);
    localparam logic [LVL_W-1:0] THR_LVL = LVL_W'(BURST_THR);
    localparam logic [OUT_W-1:0] OUT_LIM = OUT_W'(MAX_OUT);

    bus_state_e        state_q, state_d;
    bus_evt_t          evt;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  issued_q;
    logic [LEN_W-1:0]  acked_q;
    logic [OUT_W-1:0]  out_q, out_d;
    logic              go;

    assign wb_cyc   = (state_q == BUS_OPEN);
    assign wb_we    = wb_cyc;
    assign wb_stb   = wb_cyc && !fifo_empty && (out_q < OUT_LIM);
    assign wb_adr   = base_q + ADDR_W'(issued_q);
    assign wb_dat_o = fifo_dout;

    assign evt.taken = wb_stb && !wb_stall;
    assign evt.acked = wb_cyc && wb_ack;
    assign pop       = evt.taken;

    assign go = batch_ready(fifo_level >= THR_LVL, !capturing, fifo_empty);

    always_comb begin
        case (evt)
            2'b10:   out_d = out_q + 1'b1;
            2'b01:   out_d = out_q - 1'b1;
            default: out_d = out_q;
        endcase
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            BUS_IDLE: if (go) state_d = BUS_OPEN;
            BUS_OPEN: if (fifo_empty && (out_d == '0)) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BUS_IDLE;
            out_q    <= '0;
            base_q   <= '0;
            len_q    <= '0;
            issued_q <= '0;
            acked_q  <= '0;
            done     <= 1'b0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
            if (start_ok) begin
                base_q   <= cfg_base;
                len_q    <= cfg_len;
                issued_q <= '0;
                acked_q  <= '0;
                done     <= (cfg_len == '0);
            end else begin
                if (evt.taken) begin
                    issued_q <= issued_q + 1'b1;
                end
                if (evt.acked) begin
                    acked_q <= acked_q + 1'b1;
                    if (acked_q + 1'b1 == len_q) begin
                        done <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adc_burst_writer.sv
module adc_burst_writer #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 12,
    parameter int FIFO_DEPTH = 16,
    parameter int BURST_THR  = 4,
    parameter int MAX_OUT    = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              adc_strobe,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic              wb_stall,
    input  logic              wb_ack,
    output logic              done,
    output logic              overflow
);
    logic              push, pop, full, empty, capturing, start_ok;
    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  level;

    assign start_ok = start && !capturing && !wb_cyc && empty;

    adcw_capture #(.LEN_W(LEN_W)) capture_i (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .cfg_len   (cfg_len),
        .strobe    (adc_strobe),
        .fifo_full (full),
        .push      (push),
        .capturing (capturing),
        .overflow  (overflow)
    );

    adcw_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (adc_data),
        .pop   (pop),
        .dout  (head),
        .full  (full),
        .empty (empty),
        .level (level)
    );

    adcw_wb_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .LEN_W     (LEN_W),
        .LVL_W     (LVL_W),
        .BURST_THR (BURST_THR),
        .MAX_OUT   (MAX_OUT)
    ) engine_i (
        .clk        (clk),
        .rst        (rst),
        .start_ok   (start_ok),
        .cfg_base   (cfg_base),
        .cfg_len    (cfg_len),
        .capturing  (capturing),
        .fifo_empty (empty),
        .fifo_level (level),
        .fifo_dout  (head),
        .pop        (pop),
        .wb_cyc     (wb_cyc),
        .wb_stb     (wb_stb),
        .wb_we      (wb_we),
        .wb_adr     (wb_adr),
        .wb_dat_o   (wb_dat_o),
        .wb_stall   (wb_stall),
        .wb_ack     (wb_ack),
        .done       (done)
    );
endmodule

// File: rtl/adcw_checker.sv
module adcw_checker #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int MAX_OUT = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic              wb_we,
    input logic [ADDR_W-1:0] wb_adr,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic              wb_stall,
    input logic              wb_ack,
    input logic              done,
    input logic              overflow
);
    int unsigned pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 0;
        end else begin
            pending <= pending + ((wb_stb && !wb_stall) ? 1 : 0)
                               - ((wb_cyc && wb_ack) ? 1 : 0);
        end
    end

    // R2
    stb_inside_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        wb_stb |-> (wb_cyc && wb_we));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb && wb_stall) |=> (wb_stb && $stable(wb_adr) && $stable(wb_dat_o)));

    // R6
    max_pending_chk: assert property (@(posedge clk) disable iff (rst)
        pending <= MAX_OUT);

    // R7
    cyc_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wb_cyc) |-> (pending == 0));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !start) |=> overflow);

    // R9
    done_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wb_cyc);
endmodule

bind adc_burst_writer adcw_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MAX_OUT (MAX_OUT)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_o (wb_dat_o),
    .wb_stall (wb_stall),
    .wb_ack   (wb_ack),
    .done     (done),
    .overflow (overflow)
);

// File: tb/adc_burst_writer_tb.sv
module adc_burst_writer_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 12;
    localparam int THR    = 4;
    localparam int MAXO   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [DATA_W-1:0] adc_data = '0;
    logic              adc_strobe = 1'b0;
    logic              wb_cyc, wb_stb, wb_we, done, overflow;
    logic [ADDR_W-1:0] wb_adr;
    logic [DATA_W-1:0] wb_dat_o;
    logic              wb_stall = 1'b0;
    logic              wb_ack = 1'b0;

    adc_burst_writer dut_i (
        .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .adc_data(adc_data), .adc_strobe(adc_strobe), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_stall(wb_stall),
        .wb_ack(wb_ack), .done(done), .overflow(overflow)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int cyc_n = 0;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    // memory target model
    logic [7:0] mem [0:511];
    bit         wr_flag [0:511];
    int  wr_cnt, dup_cnt, max_out, stall_viol;
    bit  cyc_seen;
    int  stall_pct = 0;
    int  lat_max = 1;
    bit  ack_hold = 1'b0;
    int  pend_due [0:31];
    int  p_head = 0, p_tail = 0, p_cnt = 0;
    bit  prev_sst = 1'b0;
    logic [ADDR_W-1:0] prev_adr;
    logic [DATA_W-1:0] prev_dat;
    int  exp_s [0:63];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pick_stall(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    initial begin
        @(negedge clk);
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_sst && !(wb_stb && wb_adr == prev_adr && wb_dat_o == prev_dat))
                    stall_viol++;
                if (!ack_hold && p_cnt > 0 && pend_due[p_head] <= cyc_n) begin
                    wb_ack = 1'b1;
                    p_head = (p_head + 1) % 32;
                    p_cnt--;
                end else begin
                    wb_ack = 1'b0;
                end
                wb_stall = pick_stall(stall_pct);
                if (wb_cyc) cyc_seen = 1'b1;
                if (wb_stb && !wb_stall) begin
                    if (wr_flag[wb_adr[8:0]]) dup_cnt++;
                    mem[wb_adr[8:0]] = wb_dat_o;
                    wr_flag[wb_adr[8:0]] = 1'b1;
                    wr_cnt++;
                    pend_due[p_tail] = cyc_n + 1 + int'($urandom % lat_max);
                    p_tail = (p_tail + 1) % 32;
                    p_cnt++;
                end
                if (p_cnt > max_out) max_out = p_cnt;
                prev_sst = wb_stb && wb_stall;
                prev_adr = wb_adr;
                prev_dat = wb_dat_o;
            end
        end
    end

    task automatic clear_target(input int spct, input int lmax);
        for (int i = 0; i < 512; i++) wr_flag[i] = 1'b0;
        wr_cnt = 0; dup_cnt = 0; max_out = 0; stall_viol = 0; cyc_seen = 1'b0;
        stall_pct = spct; lat_max = lmax;
    endtask

    task automatic pulse_start(input int base, input int len);
        @(negedge clk);
        cfg_base = ADDR_W'(base);
        cfg_len  = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input int gap);
        @(negedge clk);
        adc_data = d;
        adc_strobe = 1'b1;
        @(negedge clk);
        adc_strobe = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    task automatic verify(input int base, input int len);
        int bad = 0;
        for (int i = 0; i < len; i++)
            if (!wr_flag[(base + i) % 512] || mem[(base + i) % 512] != exp_s[i][7:0]) bad++;
        check(done == 1'b1, "R9 done after run", int'(done), 1);
        check(bad == 0, "R2 data/address mismatches", bad, 0);
        check(wr_cnt == len && dup_cnt == 0, "R1 write count", wr_cnt, len);
        check(wb_cyc == 1'b0 && p_cnt == 0, "R7 cycle closed, none pending", p_cnt, 0);
        check(overflow == 1'b0, "R8 no overflow", int'(overflow), 0);
        check(max_out <= MAXO, "R6 outstanding bound", max_out, MAXO);
        check(stall_viol == 0, "R5 held during stall", stall_viol, 0);
    endtask

    task automatic run_capture(input int base, input int len, input int gmin, input int gmax,
                               input int spct, input int lmax);
        clear_target(spct, lmax);
        pulse_start(base, len);
        check(done == 1'b0 && overflow == 1'b0, "R9 done cleared by start", int'(done), 0);
        for (int i = 0; i < len; i++) begin
            exp_s[i] = int'($urandom % 256);
            send(exp_s[i][7:0], gmin + int'($urandom % (gmax - gmin + 1)));
        end
        wait_done(2000);
        verify(base, len);
        // R1: strobes after the run create no writes
        send(8'hA5, 2);
        send(8'h5A, 2);
        repeat (10) @(negedge clk);
        check(wr_cnt == len, "R1 late strobes ignored", wr_cnt, len);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) begin
            wr_flag[i] = 1'b0;
            mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!wb_cyc && !wb_stb && !done && !overflow, "R11 reset state",
              int'({wb_cyc, wb_stb, done, overflow}), 0);

        // R9: zero-length run
        clear_target(0, 1);
        pulse_start(10, 0);
        check(done == 1'b1, "R9 zero length done", int'(done), 1);
        repeat (8) @(negedge clk);
        check(cyc_seen == 1'b0, "R9 zero length no bus", int'(cyc_seen), 0);
        check(done == 1'b1, "R9 done holds", int'(done), 1);

        // R3 threshold, R10 start ignored while busy
        clear_target(0, 1);
        pulse_start(40, 20);
        for (int i = 0; i < THR - 1; i++) begin
            exp_s[i] = 16 + i;
            send(exp_s[i][7:0], 3);
        end
        repeat (10) @(negedge clk);
        check(cyc_seen == 1'b0, "R3 below threshold idle", int'(cyc_seen), 0);
        pulse_start(300, 5);
        exp_s[THR-1] = 99;
        send(8'd99, 0);
        repeat (2) @(negedge clk);
        check(cyc_seen == 1'b1, "R3 threshold opens cycle", int'(cyc_seen), 1);
        for (int i = THR; i < 20; i++) begin
            exp_s[i] = int'($urandom % 256);
            send(exp_s[i][7:0], 3);
        end
        wait_done(2000);
        verify(40, 20);
        check(wr_flag[300] == 1'b0, "R10 stray start ignored", int'(wr_flag[300]), 0);

        // R4 tails below threshold
        run_capture(100, 3, 2, 5, 0, 2);
        run_capture(120, 6, 2, 5, 30, 4);

        // R6 outstanding cap with acks held
        clear_target(0, 1);
        ack_hold = 1'b1;
        pulse_start(200, 12);
        for (int i = 0; i < 12; i++) begin
            exp_s[i] = 200 - i;
            send(exp_s[i][7:0], 1);
        end
        repeat (10) @(negedge clk);
        check(max_out == MAXO, "R6 cap reached", max_out, MAXO);
        check(wb_stb == 1'b0 && wb_cyc == 1'b1, "R6 strobe low at cap", int'(wb_stb), 0);
        ack_hold = 1'b0;
        wait_done(2000);
        verify(200, 12);

        // R8 overflow under a stalled bus
        clear_target(100, 1);
        pulse_start(0, 40);
        for (int i = 0; i < 24; i++) send(8'(i), 1);
        check(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
        stall_pct = 0;
        for (int i = 0; i < 200 && !done; i++) send(8'(i), 1);
        wait_done(500);
        check(done == 1'b1 && overflow == 1'b1, "R8 flag sticky to done", int'(overflow), 1);
        check(wr_cnt == 40, "R1 stored count with losses", wr_cnt, 40);
        pulse_start(0, 0);
        check(overflow == 1'b0, "R8 cleared by start", int'(overflow), 0);

        // dense burst, then constrained random runs
        run_capture(260, 50, 1, 2, 0, 2);
        for (int r = 0; r < 6; r++)
            run_capture(int'($urandom % 200), 1 + int'($urandom % 50), 4, 12,
                        int'($urandom % 50), 1 + int'($urandom % 5));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule